// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block drives the read side of a 32-bit-wide memory that can be read either asynchronously or in clocked bursts. A 16-bit configuration word is written through a single-cycle command strobe. Its fields choose between the two read modes and set the initial latency, the spacing between beats, the placement of the wait indication, the wrap behaviour and the burst length.

In synchronous mode a request with an address strobe latches a start address. After the programmed latency the block fetches one double-word per beat from an internal array model. It presents each word together with its address and a one-cycle valid strobe. A linear burst that starts off a 4-word boundary needs one extra internal cycle every time it enters a new group of four. The block inserts that cycle and marks it by pulling the active-low ready output low. In asynchronous mode the array word follows the address combinationally.

The array model returns, for address `a`, the 32-bit value `(a * 0x9E3779B1) ^ 0x5A5A5A5A`, computed modulo 2^32.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset the configuration selects asynchronous reads, latency code 2, single-cycle beats, late ready, wrap mode and length 4. `rdy_l` is 1 and `data_valid` is 0.
- R2: While configuration bit 15 is 1, `data_out` equals the array word of `addr_in` and `beat_addr` equals `addr_in`, both combinationally. `data_valid` stays 0, `rdy_l` stays 1, and address strobes are ignored.
- R3: With bit 15 at 0, an edge that samples `rd_req` = 1 and `addr_latch` = 1 latches `addr_in`. The first beat of that burst is visible after the X-th following rising edge, where X = code + 1 and code is taken from bits 13:11. That beat carries the start address and its array word.
- R4: Bit 9 = 0 gives one beat per clock. Bit 9 = 1 gives one beat every second clock. `data_valid` is high for exactly one cycle per beat.
- R5: In wrap mode (bit 3 = 0, length 4 or 8), successive beat addresses count up inside the aligned block of the burst length and return to its base.
- R6: When bit 3 = 1 or the length is continuous, each beat address is the previous one plus 1, across every boundary.
- R7: Bits 2:0 encode the length: 001 gives 4, 010 gives 8, 111 gives continuous. A write with any other code leaves the length unchanged.
- R8: Latency codes 2 to 6 (3 to 7 cycles) are accepted. A write carrying code 0, 1 or 7 leaves the latency unchanged.
- R9: A linear burst that starts at an address with bits 1:0 = 0 has no inserted cycles, and `rdy_l` stays 1.
- R10: In a linear burst that started unaligned, every beat whose address has bits 1:0 = 0 is delayed by one extra cycle. With bit 8 = 0, `rdy_l` is 0 for exactly that inserted cycle.
- R11: With bit 8 = 1, the `rdy_l` low cycle moves one cycle earlier. It then coincides with the beat that precedes the delayed one.
- R12: An edge that samples `rd_req` = 0 ends the burst. `data_valid` is 0 from the next cycle until a new burst delivers its first beat.
- R13: A new address strobe during a burst restarts it from the new address with the full latency.
- R14: `pwr_dn` sampled high restores the reset configuration of R1 and ends any burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_dn | input | 1 | Power-down request; restores configuration and aborts the burst |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| rd_req | input | 1 | Read request; its removal ends the burst |
| addr_latch | input | 1 | Start-address strobe |
| addr_in | input | AW | Double-word address |
| data_out | output | 32 | Array word of the current beat, or of `addr_in` in asynchronous mode |
| beat_addr | output | AW | Address of the word on `data_out` |
| data_valid | output | 1 | One-cycle strobe per synchronous beat |
| rdy_l | output | 1 | Low marks an inserted wait cycle, or the cycle before it |

## Verification
Most internal faults reach the ports within one beat. A wrong next-address step shows up as a wrong `beat_addr` and word on the beat after the fault. A miscounted gap moves `data_valid` by a cycle at once. A missing or extra inserted cycle changes both the `rdy_l` pulse and the timing of the next beat within four beats of the first crossing.

Configuration faults appear later. They show only on the first burst or asynchronous read that uses the damaged field. That is why every field is written and then exercised by a burst in turn.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int CFG_W  = 16;
  localparam int WORD_W = 32;

  // configuration bit positions
  localparam int B_ASYNC  = 15;
  localparam int B_XHI    = 13;
  localparam int B_XLO    = 11;
  localparam int B_Y2     = 9;
  localparam int B_EARLY  = 8;
  localparam int B_LINEAR = 3;
  localparam int B_LENHI  = 2;

  localparam logic [2:0] XCODE_MIN = 3'd2;
  localparam logic [2:0] XCODE_MAX = 3'd6;

  typedef enum logic [2:0] {
    LEN_4    = 3'b001,
    LEN_8    = 3'b010,
    LEN_CONT = 3'b111
  } len_e;

  typedef struct packed {
    logic       async_rd;
    logic [2:0] xcode;
    logic       y2;
    logic       rdy_early;
    logic       linear;
    len_e       len;
  } cfg_t;

  localparam cfg_t CFG_RST = '{1'b1, 3'd2, 1'b0, 1'b0, 1'b0, LEN_4};

  function automatic logic [WORD_W-1:0] arr_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A5A5A;
  endfunction
endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output cfg_t             cfg
);
  cfg_t cfg_q, cfg_d;
  logic [2:0] x_new;
  logic       x_ok;
  logic       unused_rsvd;

  assign unused_rsvd = ^{wr_data[14], wr_data[10], wr_data[7:4]};
  assign x_new = wr_data[B_XHI:B_XLO];
  assign x_ok  = (x_new >= XCODE_MIN) && (x_new <= XCODE_MAX);

  always_comb begin
    cfg_d = cfg_q;
    if (pwr_dn) begin
      cfg_d = CFG_RST;
    end else if (wr_en) begin
      cfg_d.async_rd  = wr_data[B_ASYNC];
      cfg_d.y2        = wr_data[B_Y2];
      cfg_d.rdy_early = wr_data[B_EARLY];
      cfg_d.linear    = wr_data[B_LINEAR];
      if (x_ok) cfg_d.xcode = x_new;
      case (wr_data[B_LENHI:0])
        LEN_4, LEN_8, LEN_CONT: cfg_d.len = len_e'(wr_data[B_LENHI:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.len inside {LEN_4, LEN_8, LEN_CONT}); // R7
  AST_XCODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.xcode >= XCODE_MIN) && (cfg_q.xcode <= XCODE_MAX)); // R8
  AST_PD_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (cfg_q == CFG_RST)); // R14
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_pkg::*;
#(
  parameter int AW      = 20,
  parameter int GRP_LOG = 2
) (
  input  logic [AW-1:0] cur,
  input  logic          start_unal,
  input  logic          linear,
  input  len_e          len,
  output logic [AW-1:0] nxt,
  output logic          need_wait
);
  localparam int L4_LOG = 2;
  localparam int L8_LOG = 3;

  logic wrap_mode;
  assign wrap_mode = !linear && (len != LEN_CONT);

  always_comb begin
    nxt = cur + AW'(1);
    if (wrap_mode) begin
      if (len == LEN_8)
        nxt = {cur[AW-1:L8_LOG], cur[L8_LOG-1:0] + L8_LOG'(1)};
      else
        nxt = {cur[AW-1:L4_LOG], cur[L4_LOG-1:0] + L4_LOG'(1)};
    end
  end

  assign need_wait = !wrap_mode && start_unal && (nxt[GRP_LOG-1:0] == '0);
endmodule

// File: rtl/burst_array.sv
module burst_array
  import burst_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic [AW-1:0]     fetch_addr,
  input  logic [AW-1:0]     async_addr,
  output logic [WORD_W-1:0] sync_word,
  output logic [WORD_W-1:0] async_word
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (fetch_en) word_q <= arr_word(32'(fetch_addr));
  end

  assign sync_word  = word_q;
  assign async_word = arr_word(32'(async_addr));
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import burst_pkg::*;
#(
  parameter int AW      = 20,
  parameter int GRP_LOG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              rd_req,
  input  logic              addr_latch,
  input  logic [AW-1:0]     addr_in,
  output logic [WORD_W-1:0] data_out,
  output logic [AW-1:0]     beat_addr,
  output logic              data_valid,
  output logic              rdy_l
);
  localparam int GAP_W = 3;

  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  cfg_t cfg;
  burst_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_i), .pwr_dn(pwr_dn),
    .wr_en(cfg_we), .wr_data(cfg_wdata), .cfg(cfg)
  );

  logic             active_q, active_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [AW-1:0]    cur_q, cur_d;
  logic             unal_q, unal_d;
  logic             wpend_q, wpend_d;
  logic             dv_q, dv_d;
  logic             rdy_q, rdy_d;
  logic [AW-1:0]    baddr_q, baddr_d;
  logic             fetch_en;
  logic [AW-1:0]    nxt;
  logic             need_wait;
  logic             start, stop;
  logic [WORD_W-1:0] sync_word, async_word;

  burst_addr_step #(.AW(AW), .GRP_LOG(GRP_LOG)) u_step (
    .cur(cur_q), .start_unal(unal_q), .linear(cfg.linear), .len(cfg.len),
    .nxt(nxt), .need_wait(need_wait)
  );

  burst_array #(.AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_i), .fetch_en(fetch_en), .fetch_addr(cur_q),
    .async_addr(addr_in), .sync_word(sync_word), .async_word(async_word)
  );

  assign start = !cfg.async_rd && rd_req && addr_latch;
  assign stop  = pwr_dn || cfg.async_rd || !rd_req;

  always_comb begin
    active_d = active_q;
    gap_d    = gap_q;
    cur_d    = cur_q;
    unal_d   = unal_q;
    wpend_d  = wpend_q;
    baddr_d  = baddr_q;
    dv_d     = 1'b0;
    rdy_d    = 1'b1;
    fetch_en = 1'b0;
    if (stop) begin
      active_d = 1'b0;
    end else if (start) begin
      active_d = 1'b1;
      cur_d    = addr_in;
      unal_d   = (addr_in[GRP_LOG-1:0] != '0);
      gap_d    = cfg.xcode;
      wpend_d  = 1'b0;
    end else if (active_q) begin
      if (gap_q == '0) begin
        dv_d     = 1'b1;
        fetch_en = 1'b1;
        baddr_d  = cur_q;
        cur_d    = nxt;
        wpend_d  = need_wait;
        gap_d    = GAP_W'(cfg.y2) + GAP_W'(need_wait);
        if (cfg.rdy_early && need_wait) rdy_d = 1'b0;
      end else begin
        gap_d = gap_q - GAP_W'(1);
        if (!cfg.rdy_early && wpend_q && (gap_q == GAP_W'(1))) rdy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      active_q <= 1'b0;
      gap_q    <= '0;
      cur_q    <= '0;
      unal_q   <= 1'b0;
      wpend_q  <= 1'b0;
      dv_q     <= 1'b0;
      rdy_q    <= 1'b1;
      baddr_q  <= '0;
    end else begin
      active_q <= active_d;
      gap_q    <= gap_d;
      cur_q    <= cur_d;
      unal_q   <= unal_d;
      wpend_q  <= wpend_d;
      dv_q     <= dv_d;
      rdy_q    <= rdy_d;
      baddr_q  <= baddr_d;
    end
  end

  assign data_out   = cfg.async_rd ? async_word : sync_word;
  assign beat_addr  = cfg.async_rd ? addr_in : baddr_q;
  assign data_valid = dv_q;
  assign rdy_l      = rdy_q;

  AST_ASYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg.async_rd && $past(cfg.async_rd)) |-> (rdy_l && !data_valid)); // R2
  AST_DV_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_i)
    data_valid |-> $past(rd_req)); // R12
  AST_WAIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_i)
    !rdy_l |=> rdy_l); // R10
  AST_Y2_SPACING: assert property (@(posedge clk) disable iff (!rst_i)
    (data_valid && $past(cfg.y2)) |=> !data_valid); // R4
endmodule

// File: tb/burst_rd_seq_test.sv
module burst_rd_seq_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n, pwr_dn, cfg_we, rd_req, addr_latch;
  logic [15:0]   cfg_wdata;
  logic [AW-1:0] addr_in;
  logic [31:0]   data_out;
  logic [AW-1:0] beat_addr;
  logic          data_valid, rdy_l;

  always #4 clk = ~clk;

  burst_rd_seq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .rd_req(rd_req), .addr_latch(addr_latch),
    .addr_in(addr_in), .data_out(data_out), .beat_addr(beat_addr),
    .data_valid(data_valid), .rdy_l(rdy_l)
  );

  int checks = 0, errors = 0;
  string tag = "R1";
  bit chk_en = 0, finished = 0;

  // reference model state
  int cyc = 0;
  bit m_async, m_y2, m_early, m_lin, m_act, m_unal;
  int m_x, m_len, m_cur, m_emit, m_rlow;
  bit e_dv, e_rdy;
  int e_addr;

  function automatic logic [31:0] wd(int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A5A5A;
  endfunction

  function automatic logic [15:0] mk(bit as, int x, bit y2, bit early, bit lin, logic [2:0] len);
    logic [15:0] v = '0;
    v[15] = as; v[13:11] = 3'(x); v[9] = y2; v[8] = early; v[3] = lin; v[2:0] = len;
    return v;
  endfunction

  task automatic m_rst();
    m_async = 1; m_x = 2; m_y2 = 0; m_early = 0; m_lin = 0; m_len = 4; m_act = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    e_dv = 0; e_rdy = 1;
    if (!rst_n || pwr_dn) m_rst();
    else begin
      if (!m_async && rd_req && addr_latch) begin
        m_act = 1; m_cur = int'(addr_in); m_unal = (m_cur % 4) != 0;
        m_emit = cyc + m_x + 1; m_rlow = -1;
      end else if (m_async || !rd_req) m_act = 0;
      else if (m_act) begin
        if (cyc == m_emit) begin
          int nx, y;
          bit w, lin;
          e_dv = 1; e_addr = m_cur;
          lin = m_lin || (m_len == 0);
          if (lin) nx = (m_cur + 1) % (1 << AW);
          else nx = (m_cur - (m_cur % m_len)) + ((m_cur + 1) % m_len);
          w = lin && m_unal && (nx % 4 == 0);
          y = m_y2 ? 2 : 1;
          m_emit = cyc + y + int'(w);
          if (w) m_rlow = m_early ? cyc : cyc + y;
          m_cur = nx;
        end
        if (cyc == m_rlow) e_rdy = 0;
      end
      if (cfg_we) begin
        m_async = cfg_wdata[15]; m_y2 = cfg_wdata[9]; m_early = cfg_wdata[8]; m_lin = cfg_wdata[3];
        if (cfg_wdata[13:11] >= 2 && cfg_wdata[13:11] <= 6) m_x = int'(cfg_wdata[13:11]);
        case (cfg_wdata[2:0])
          3'b001: m_len = 4;
          3'b010: m_len = 8;
          3'b111: m_len = 0;
          default: ;
        endcase
      end
    end
  end

  task automatic cmp(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      cmp("data_valid", longint'(data_valid), longint'(e_dv));
      cmp("rdy_l", longint'(rdy_l), longint'(e_rdy));
      if (e_dv) begin
        cmp("beat_addr", longint'(beat_addr), longint'(e_addr));
        cmp("data_out", longint'(data_out), longint'(wd(e_addr)));
      end
      if (m_async) begin
        cmp("async data_out", longint'(data_out), longint'(wd(int'(addr_in))));
        cmp("async beat_addr", longint'(beat_addr), longint'(addr_in));
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_cfg(logic [15:0] v);
    cfg_we = 1; cfg_wdata = v; tick(1); cfg_we = 0; tick(1);
  endtask

  task automatic burst(int a, int n);
    rd_req = 1; addr_latch = 1; addr_in = AW'(a); tick(1);
    addr_latch = 0; tick(n);
    rd_req = 0; tick(3);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pwr_dn = 0; cfg_we = 0; cfg_wdata = '0; rd_req = 0; addr_latch = 0; addr_in = '0;
    tick(3); rst_n = 1; tick(4); chk_en = 1;
    tag = "R1"; tick(3);
    tag = "R2";
    for (int i = 0; i < 6; i++) begin addr_in = AW'(i * 37 + 5); tick(1); end
    burst(20'h00123, 6);
    tag = "R3/R5"; wr_cfg(mk(0, 2, 0, 0, 0, 3'b001)); burst(20'h12, 12);
    tag = "R5"; wr_cfg(mk(0, 3, 0, 0, 0, 3'b010)); burst(20'h2D, 20);
    tag = "R4/R9"; wr_cfg(mk(0, 6, 1, 0, 1, 3'b001)); burst(20'h40, 30);
    tag = "R6/R10"; wr_cfg(mk(0, 2, 0, 0, 0, 3'b111)); burst(20'h53, 20);
    tag = "R11"; wr_cfg(mk(0, 2, 0, 1, 1, 3'b010)); burst(20'h61, 20);
    tag = "R4/R10"; wr_cfg(mk(0, 4, 1, 0, 1, 3'b001)); burst(20'h72, 30);
    tag = "R7"; wr_cfg(mk(0, 2, 0, 0, 0, 3'b010)); wr_cfg(mk(0, 2, 0, 0, 0, 3'b011));
    burst(20'h85, 20);
    tag = "R8"; wr_cfg(mk(0, 0, 0, 0, 0, 3'b010)); burst(20'h90, 10);
    wr_cfg(mk(0, 7, 0, 0, 0, 3'b100)); burst(20'h9A, 10);
    tag = "R12"; wr_cfg(mk(0, 5, 0, 0, 1, 3'b111)); burst(20'hC1, 9); tick(8);
    tag = "R13";
    rd_req = 1; addr_latch = 1; addr_in = 20'hA3; tick(1); addr_latch = 0; tick(7);
    addr_latch = 1; addr_in = 20'hB0; tick(1); addr_latch = 0; tick(12);
    rd_req = 0; tick(3);
    tag = "R14";
    rd_req = 1; addr_latch = 1; addr_in = 20'hD2; tick(1); addr_latch = 0; tick(9);
    pwr_dn = 1; tick(1); pwr_dn = 0; tick(2);
    addr_latch = 1; addr_in = 20'h0E7; tick(1); addr_latch = 0; addr_in = 20'h0F1; tick(5);
    rd_req = 0; tick(3);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule